// File: doc/BRIEF.md
# Integer ALU with Local Operation Decoder

This block carries out the integer arithmetic and logic step of a simple load/store processor. It takes two operands, a 2-bit operation class from the main controller and the 6-bit function field of the instruction. A small decoder turns the class and the function field into an internal operation select. The datapath then forms the result together with a zero flag and a signed-overflow flag. A qualifier input marks the operation as unsigned, which suppresses the overflow flag.

Memory instructions use the fixed "add" class to form addresses, and conditional branches use the fixed "subtract" class so that the zero flag can test for equality. Register-to-register instructions let the function field pick the operation. Subtraction shares the adder: the second operand is inverted and a carry of 1 enters bit 0. The adder is a ripple chain of full adders, so the carry into the top bit can be compared with the carry out of it to detect overflow. The outputs are registered, so the result appears one clock after the operands are sampled.

Top module: `alu_unit`

## Requirements
- R1: With class 00 the block adds, and with class 01 it subtracts (a minus b), whatever the function field holds.
- R2: With class 10 the function field selects the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 100111 NOR, 101010 set-on-less-than.
- R3: Class 11, and class 10 with any function value not listed in R2, give a result of 0 with the zero flag 1 and the overflow flag 0.
- R4: Add and subtract wrap modulo 2^32 in two's complement.
- R5: AND, OR and NOR act bit by bit on the two operands.
- R6: Set-on-less-than puts the sign bit (bit 31) of the raw difference a minus b into bit 0 of the result and clears bits 31 to 1.
- R7: The zero flag is 1 exactly when all 32 result bits are 0.
- R8: For a signed add or subtract, the overflow flag is the carry into bit 31 XOR the carry out of bit 31.
- R9: The overflow flag is 0 whenever the unsigned qualifier is 1, and for every operation other than add and subtract.
- R10: Outputs change one clock after the inputs are sampled; a synchronous active-high reset sets the result to 0, the zero flag to 1 and the overflow flag to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| op_class | input | 2 | Operation class from the main controller |
| fn_code | input | 6 | Function field of the instruction |
| unsigned_mode | input | 1 | 1 marks the operation unsigned and suppresses overflow |
| result_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered flag: result is all zeros |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
The bench aims at the overflow boundaries: the largest positive value plus one, the most negative value minus one and zero minus the most negative value must raise overflow when signed and stay clear when unsigned, while all-ones plus one wraps to zero without overflow, so a design using the carry out alone would flag it. Set-on-less-than is driven with equal operands, a negative versus positive pair and the most negative value against one, where the raw sign bit gives 0; a design that corrected for overflow or left upper bits set would differ. Fixed classes are paired with conflicting function fields, and unlisted codes must yield a zero result, catching a decoder that falls through to a real operation. A logic result of all zeros checks that the zero flag follows the result rather than the adder.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int CLS_W = 2;
  localparam int FN_W  = 6;

  typedef enum logic [3:0] {
    SEL_AND  = 4'b0000,
    SEL_OR   = 4'b0001,
    SEL_ADD  = 4'b0010,
    SEL_SUB  = 4'b0110,
    SEL_SLT  = 4'b0111,
    SEL_NOR  = 4'b1100,
    SEL_NONE = 4'b1111
  } alu_sel_e;

  localparam logic [CLS_W-1:0] CLS_ADDR   = 2'b00;
  localparam logic [CLS_W-1:0] CLS_CMP    = 2'b01;
  localparam logic [CLS_W-1:0] CLS_REGREG = 2'b10;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_NOR = 6'b100111;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;
endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_pkg::*;
(
  input  logic [CLS_W-1:0] op_class,
  input  logic [FN_W-1:0]  fn_code,
  output alu_sel_e         sel
);
  alu_sel_e fn_sel;

  always_comb begin
    case (fn_code)
      FN_ADD:  fn_sel = SEL_ADD;
      FN_SUB:  fn_sel = SEL_SUB;
      FN_AND:  fn_sel = SEL_AND;
      FN_OR:   fn_sel = SEL_OR;
      FN_NOR:  fn_sel = SEL_NOR;
      FN_SLT:  fn_sel = SEL_SLT;
      default: fn_sel = SEL_NONE;
    endcase
  end

  always_comb begin
    case (op_class)
      CLS_ADDR:   sel = SEL_ADD;
      CLS_CMP:    sel = SEL_SUB;
      CLS_REGREG: sel = fn_sel;
      default:    sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         carry_top_in,
  output logic         carry_out
);
  logic [W:0] c;
  assign c[0] = cin;

  for (genvar gi = 0; gi < W; gi++) begin : g_fa
    assign sum[gi]  = x[gi] ^ y[gi] ^ c[gi];
    assign c[gi+1]  = (x[gi] & y[gi]) | (x[gi] & c[gi]) | (y[gi] & c[gi]);
  end

  assign carry_top_in = c[W-1];
  assign carry_out    = c[W];
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_sel_e     sel,
  input  logic         unsigned_mode,
  output logic [W-1:0] res,
  output logic         zero,
  output logic         ovf
);
  logic         invert_b;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         c_top_in;
  logic         c_out;
  logic         is_arith;

  assign invert_b = (sel == SEL_SUB) || (sel == SEL_SLT);
  assign b_eff    = invert_b ? ~b : b;

  alu_ripple_add #(.W(W)) u_add (
    .x            (a),
    .y            (b_eff),
    .cin          (invert_b),
    .sum          (sum),
    .carry_top_in (c_top_in),
    .carry_out    (c_out)
  );

  always_comb begin
    res = '0;
    case (sel)
      SEL_AND: res = a & b;
      SEL_OR:  res = a | b;
      SEL_NOR: res = ~(a | b);
      SEL_ADD: res = sum;
      SEL_SUB: res = sum;
      SEL_SLT: res[0] = sum[W-1];
      default: res = '0;
    endcase
  end

  assign is_arith = (sel == SEL_ADD) || (sel == SEL_SUB);
  assign zero     = ~|res;
  assign ovf      = is_arith & ~unsigned_mode & (c_top_in ^ c_out);
endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     a_in,
  input  logic [W-1:0]     b_in,
  input  logic [CLS_W-1:0] op_class,
  input  logic [FN_W-1:0]  fn_code,
  input  logic             unsigned_mode,
  output logic [W-1:0]     result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  alu_sel_e     sel;
  logic [W-1:0] res_c;
  logic         zero_c;
  logic         ovf_c;
  alu_sel_e     sel_q;
  logic         uns_q;

  alu_op_decode u_dec (
    .op_class (op_class),
    .fn_code  (fn_code),
    .sel      (sel)
  );

  alu_datapath #(.W(W)) u_dp (
    .a             (a_in),
    .b             (b_in),
    .sel           (sel),
    .unsigned_mode (unsigned_mode),
    .res           (res_c),
    .zero          (zero_c),
    .ovf           (ovf_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      zero_o   <= 1'b1;
      ovf_o    <= 1'b0;
      sel_q    <= SEL_AND;
      uns_q    <= 1'b0;
    end else begin
      result_o <= res_c;
      zero_o   <= zero_c;
      ovf_o    <= ovf_c;
      sel_q    <= sel;
      uns_q    <= unsigned_mode;
    end
  end

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    zero_o == (result_o == '0));

  // R6
  slt_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SEL_SLT) |-> (result_o[W-1:1] == '0));

  // R9
  ovf_kind_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (((sel_q == SEL_ADD) || (sel_q == SEL_SUB)) && !uns_q));

  // R3
  unused_code_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SEL_NONE) |-> (result_o == '0 && !ovf_o));
endmodule

// File: tb/tb_alu_unit.sv
module tb_alu_unit;
  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [1:0]  cls;
    logic [5:0]  fn;
    logic        uns;
    logic [31:0] res;
    logic        z;
    logic        v;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{32'd5, 32'd7, 2'b00, 6'b100010, 1'b0, 32'd12, 1'b0, 1'b0, 8'd1},                          // R1
    '{32'd7, 32'd7, 2'b01, 6'b100000, 1'b0, 32'd0, 1'b1, 1'b0, 8'd1},                           // R1
    '{32'h7FFFFFFF, 32'd1, 2'b10, 6'b100000, 1'b0, 32'h80000000, 1'b0, 1'b1, 8'd8},             // R8
    '{32'h7FFFFFFF, 32'd1, 2'b10, 6'b100000, 1'b1, 32'h80000000, 1'b0, 1'b0, 8'd9},             // R9
    '{32'h80000000, 32'd1, 2'b10, 6'b100010, 1'b0, 32'h7FFFFFFF, 1'b0, 1'b1, 8'd8},             // R8
    '{32'h80000000, 32'd1, 2'b10, 6'b100010, 1'b1, 32'h7FFFFFFF, 1'b0, 1'b0, 8'd9},             // R9
    '{32'hF0F0F0F0, 32'hFF00FF00, 2'b10, 6'b100100, 1'b0, 32'hF000F000, 1'b0, 1'b0, 8'd5},      // R5
    '{32'h0F0F0000, 32'h000000FF, 2'b10, 6'b100101, 1'b0, 32'h0F0F00FF, 1'b0, 1'b0, 8'd5},      // R5
    '{32'h0000FFFF, 32'h00FF0000, 2'b10, 6'b100111, 1'b0, 32'hFF000000, 1'b0, 1'b0, 8'd2},      // R2
    '{32'hFFFFFFFF, 32'd1, 2'b10, 6'b101010, 1'b0, 32'd1, 1'b0, 1'b0, 8'd6},                    // R6
    '{32'd3, 32'd3, 2'b10, 6'b101010, 1'b0, 32'd0, 1'b1, 1'b0, 8'd6},                           // R6
    '{32'h80000000, 32'd1, 2'b10, 6'b101010, 1'b0, 32'd0, 1'b1, 1'b0, 8'd6},                    // R6
    '{32'h12345678, 32'd1, 2'b10, 6'b000000, 1'b0, 32'd0, 1'b1, 1'b0, 8'd3},                    // R3
    '{32'h12345678, 32'd1, 2'b11, 6'b100000, 1'b0, 32'd0, 1'b1, 1'b0, 8'd3},                    // R3
    '{32'hFFFFFFFF, 32'd1, 2'b00, 6'b000000, 1'b0, 32'd0, 1'b1, 1'b0, 8'd4},                    // R4
    '{32'd0, 32'h80000000, 2'b01, 6'b000000, 1'b0, 32'h80000000, 1'b0, 1'b1, 8'd8},             // R8
    '{32'd9, 32'd4, 2'b10, 6'b100010, 1'b0, 32'd5, 1'b0, 1'b0, 8'd2},                           // R2
    '{32'hAAAAAAAA, 32'h55555555, 2'b10, 6'b100100, 1'b0, 32'd0, 1'b1, 1'b0, 8'd7}              // R7
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a_in = '0;
  logic [31:0] b_in = '0;
  logic [1:0]  op_class = '0;
  logic [5:0]  fn_code = '0;
  logic        unsigned_mode = 1'b0;
  logic [31:0] result_o;
  logic        zero_o;
  logic        ovf_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu_unit dut (
    .clk           (clk),
    .rst           (rst),
    .a_in          (a_in),
    .b_in          (b_in),
    .op_class      (op_class),
    .fn_code       (fn_code),
    .unsigned_mode (unsigned_mode),
    .result_o      (result_o),
    .zero_o        (zero_o),
    .ovf_o         (ovf_o)
  );

  task automatic chk(input string what, input int req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    a_in = v.a;
    b_in = v.b;
    op_class = v.cls;
    fn_code = v.fn;
    unsigned_mode = v.uns;
  endtask

  initial begin
    // R10: reset state with inputs that would give a nonzero, overflowing sum
    drive(VECS[2]);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("reset result", 10, result_o, 32'd0);
    chk("reset zero", 10, {31'd0, zero_o}, 32'd1);
    chk("reset ovf", 10, {31'd0, ovf_o}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("vec %0d result", i), int'(VECS[i].req), result_o, VECS[i].res);
      chk($sformatf("vec %0d zero", i), int'(VECS[i].req), {31'd0, zero_o}, {31'd0, VECS[i].z});
      chk($sformatf("vec %0d ovf", i), int'(VECS[i].req), {31'd0, ovf_o}, {31'd0, VECS[i].v});
    end

    // R10: output holds previous value until the next edge, then follows
    drive(VECS[0]);
    @(posedge clk);
    @(negedge clk);
    drive(VECS[16]);
    #1;
    chk("latency hold", 10, result_o, 32'd12);
    @(posedge clk);
    @(negedge clk);
    chk("latency update", 10, result_o, 32'd5);

    // R10: reset in mid-stream clears an overflowing result
    drive(VECS[15]);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("mid reset result", 10, result_o, 32'd0);
    chk("mid reset ovf", 10, {31'd0, ovf_o}, 32'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule